// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer

This block is the host-side controller that writes one page of a byte-wide parallel EEPROM over its strobe bus. A request gives a page number, a byte count and a polling method. The block then pulls bytes from a valid/ready data stream. It drives them as a single page-load burst of write-enable strobes, spaced by timing parameters counted in clock cycles. While the stream is being consumed, it keeps each gap between strobes inside the memory's byte-load window.

After the burst, the block does not wait a fixed time. It keeps reading the memory until the device reports that the internal programming cycle is over. Two methods are available: watching bit 6 stop toggling, or watching bit 7 of the last written byte return its true value. The method is chosen per request. The result is one pulse: `done` on success, or `err` with a code that says why the job failed. The memory data bus uses separate output, output-enable and input pins, and the tri-state pad sits outside the block.

Top module: `eeprog_page_writer`

## Requirements
- R1: `req_ready` is high only while the block is idle. It falls in the cycle after a request is accepted and stays low through the single cycle in which `done` or `err` is high. `done` and `err` are one-cycle pulses and are never high together.
- R2: A request whose count is 0 pulses `err` with `err_code` = 1 in the next cycle and produces no write strobe. A count above 64 is treated as 64, so exactly 64 bytes are taken from the stream.
- R3: Every byte of a burst is written at an address whose bits [12:6] equal `req_page`. Bits [5:0] run 0, 1, 2, … in stream order. The written data equals the stream byte.
- R4: `mem_we_n` stays low for at least `T_WP` cycles per strobe and high for at least `T_WPH` cycles between strobes. Address and data are stable for the whole low phase.
- R5: The time from one `mem_we_n` rise to the next fall never exceeds `GAP_LIMIT` cycles. If the stream stalls past that limit, loading stops, polling proceeds on the bytes already written, and the job ends with `err_code` = 3.
- R6: `mem_dq_oe` is high only while `mem_we_n` is low. It is low in the cycle before and throughout any cycle with `mem_oe_n` low.
- R7: With `req_mode` = 0, the block ends with `done` only after two successive poll reads return the same value of bit 6.
- R8: With `req_mode` = 1, poll reads use the last address written, and the job ends with `done` once bit 7 of the read equals bit 7 of the last byte written.
- R9: If polling has not completed after `POLL_LIMIT` cycles, the job ends with `err_code` = 3 replaced by `err_code` = 2 (timeout). The pulse comes exactly `T_WPH + POLL_LIMIT` cycles after the last strobe rises.
- R10: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all high whenever `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Job request |
| req_ready | output | 1 | Block idle, request accepted |
| req_page | input | 7 | Page number (address bits 12:6) |
| req_count | input | 7 | Bytes in the job (0 rejected, above 64 clamped) |
| req_mode | input | 1 | Polling method: 0 bit-6 toggle, 1 bit-7 compare |
| wr_valid | input | 1 | Stream byte valid |
| wr_data | input | 8 | Stream byte |
| wr_ready | output | 1 | Stream byte taken |
| done | output | 1 | Job finished without error (pulse) |
| err | output | 1 | Job finished with error (pulse) |
| err_code | output | 2 | Error reason while `err`: 1 empty, 2 timeout, 3 window missed |
| mem_addr | output | 13 | Memory address |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 8 | Data from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bound checker watches the strobe bus on every cycle. It checks the low width and high width of each write pulse and the rise-to-fall window. It also checks address and data stability during a pulse, the page and ascending offset of every strobe, and the bus-release rule around reads. On the request side it checks the ready/pulse handshake and the empty-count rejection. Whether polling stops at the right moment depends on how the memory answers, so that can only be shown by the bench scenarios. These run against a behavioural memory that stays busy, toggles bit 6 and inverts bit 7. They cover completion in both modes, the clamp to 64 bytes, a stalled stream and a memory that never finishes.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;

    localparam int ADDR_W     = 13;
    localparam int DATA_W     = 8;
    localparam int OFFS_W     = 6;
    localparam int PAGE_W     = ADDR_W - OFFS_W;
    localparam int PAGE_BYTES = 1 << OFFS_W;
    localparam int CNT_W      = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_SETUP,
        S_STROBE,
        S_RECOVER,
        S_TURN,
        S_SENSE,
        S_REST,
        S_FIN
    } state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_EMPTY   = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_WINDOW  = 2'd3
    } err_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFFS_W:0]   total;
        logic              data7_mode;
    } job_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } beat_t;

    function automatic logic [OFFS_W:0] clamp_total(input logic [CNT_W-1:0] c);
        if (c > CNT_W'(PAGE_BYTES))
            return (OFFS_W + 1)'(PAGE_BYTES);
        return c[OFFS_W:0];
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eeprog_downcnt.sv
module eeprog_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/eeprog_poll_judge.sv
module eeprog_poll_judge (
    input  logic       data7_mode,
    input  logic [1:0] sample_hi,
    input  logic       have_prev,
    input  logic       prev_b6,
    input  logic       target_b7,
    output logic       finished
);
    logic toggle_still;
    logic bit7_true;

    always_comb begin
        toggle_still = have_prev && (sample_hi[0] == prev_b6);
        bit7_true    = (sample_hi[1] == target_b7);
        finished     = data7_mode ? bit7_true : toggle_still;
    end
endmodule

// File: rtl/eeprog_page_writer.sv
module eeprog_page_writer
    import eeprog_pkg::*;
#(
    parameter int T_AS       = 1,
    parameter int T_WP       = 10,
    parameter int T_WPH      = 5,
    parameter int T_RD       = 20,
    parameter int T_RH       = 5,
    parameter int GAP_LIMIT  = 10000,
    parameter int POLL_LIMIT = 300000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_mode,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int PH_MAX   = imax(imax(imax(T_AS, T_WP), imax(T_WPH, T_RD)), T_RH);
    localparam int PH_W     = $clog2(PH_MAX + 1);
    localparam int GAP_WAIT = GAP_LIMIT - T_AS;
    localparam int GAP_W    = $clog2(GAP_LIMIT + 1);
    localparam int TO_W     = $clog2(POLL_LIMIT + 1);

    state_e             state, nxt;
    job_t               job;
    beat_t              beat;
    logic [OFFS_W:0]    sent;
    logic               have_prev, prev_b6, missed;
    err_e               code_q, fin_code;

    logic               ph_load, ph_zero;
    logic [PH_W-1:0]    ph_val, ph_cnt;
    logic               gap_load, gap_zero;
    logic [GAP_W-1:0]   gap_cnt;
    logic               to_load, to_zero;
    logic [TO_W-1:0]    to_cnt;
    logic               accept, miss_now, finished, polling;
    logic [OFFS_W:0]    req_total;

    assign req_total = clamp_total(req_count);
    assign polling   = (state == S_TURN) || (state == S_SENSE) || (state == S_REST);

    eeprog_downcnt #(.W(PH_W)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val),
        .cnt(ph_cnt), .zero(ph_zero)
    );

    eeprog_downcnt #(.W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(GAP_W'(GAP_WAIT - 1)),
        .cnt(gap_cnt), .zero(gap_zero)
    );

    eeprog_downcnt #(.W(TO_W)) u_timeout (
        .clk(clk), .rst(rst), .load(to_load), .load_val(TO_W'(POLL_LIMIT - 1)),
        .cnt(to_cnt), .zero(to_zero)
    );

    eeprog_poll_judge u_judge (
        .data7_mode(job.data7_mode),
        .sample_hi (mem_dq_in[7:6]),
        .have_prev (have_prev),
        .prev_b6   (prev_b6),
        .target_b7 (beat.data[7]),
        .finished  (finished)
    );

    always_comb begin
        nxt      = state;
        ph_load  = 1'b0;
        ph_val   = '0;
        gap_load = 1'b0;
        to_load  = 1'b0;
        accept   = 1'b0;
        miss_now = 1'b0;
        fin_code = ERR_NONE;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_total == '0) begin
                        nxt      = S_FIN;
                        fin_code = ERR_EMPTY;
                    end else begin
                        nxt = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                if (wr_valid) begin
                    accept  = 1'b1;
                    nxt     = S_SETUP;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(T_AS - 1);
                end else if (sent != '0 && gap_zero) begin
                    miss_now = 1'b1;
                    nxt      = S_TURN;
                    to_load  = 1'b1;
                end
            end
            S_SETUP: begin
                if (ph_zero) begin
                    nxt     = S_STROBE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(T_WP - 1);
                end
            end
            S_STROBE: begin
                if (ph_zero) begin
                    nxt      = S_RECOVER;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(T_WPH - 1);
                    gap_load = 1'b1;
                end
            end
            S_RECOVER: begin
                if (ph_zero) begin
                    if (sent == job.total) begin
                        nxt     = S_TURN;
                        to_load = 1'b1;
                    end else begin
                        nxt = S_FETCH;
                    end
                end
            end
            S_TURN: begin
                nxt     = S_SENSE;
                ph_load = 1'b1;
                ph_val  = PH_W'(T_RD - 1);
            end
            S_SENSE: begin
                if (ph_zero) begin
                    if (finished) begin
                        nxt      = S_FIN;
                        fin_code = missed ? ERR_WINDOW : ERR_NONE;
                    end else begin
                        nxt     = S_REST;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(T_RH - 1);
                    end
                end
            end
            S_REST: begin
                if (ph_zero) begin
                    nxt     = S_SENSE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(T_RD - 1);
                end
            end
            S_FIN: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase

        // completion in the same cycle takes precedence over the deadline
        if (polling && to_zero && nxt != S_FIN) begin
            nxt      = S_FIN;
            fin_code = ERR_TIMEOUT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            job       <= '0;
            beat      <= '0;
            sent      <= '0;
            have_prev <= 1'b0;
            prev_b6   <= 1'b0;
            missed    <= 1'b0;
            code_q    <= ERR_NONE;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) begin
                job.page       <= req_page;
                job.total      <= req_total;
                job.data7_mode <= req_mode;
                sent           <= '0;
                have_prev      <= 1'b0;
                missed         <= 1'b0;
            end
            if (accept) begin
                beat.addr <= {job.page, sent[OFFS_W-1:0]};
                beat.data <= wr_data;
                sent      <= sent + 1'b1;
            end
            if (miss_now)
                missed <= 1'b1;
            if (state == S_SENSE && ph_zero) begin
                have_prev <= 1'b1;
                prev_b6   <= mem_dq_in[6];
            end
            if (nxt == S_FIN)
                code_q <= fin_code;
        end
    end

    assign req_ready  = (state == S_IDLE);
    assign wr_ready   = (state == S_FETCH);
    assign done       = (state == S_FIN) && (code_q == ERR_NONE);
    assign err        = (state == S_FIN) && (code_q != ERR_NONE);
    assign err_code   = (state == S_FIN) ? code_q : ERR_NONE;
    assign mem_addr   = beat.addr;
    assign mem_dq_out = beat.data;
    assign mem_dq_oe  = (state == S_STROBE);
    assign mem_we_n   = (state != S_STROBE);
    assign mem_oe_n   = (state != S_SENSE);
    assign mem_ce_n   = (state == S_IDLE) || (state == S_FIN);

endmodule

// File: rtl/eeprog_page_writer_chk.sv
module eeprog_page_writer_chk #(
    parameter int T_WP      = 10,
    parameter int T_WPH     = 5,
    parameter int GAP_LIMIT = 10000
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [6:0]  req_page,
    input logic [6:0]  req_count,
    input logic        done,
    input logic        err,
    input logic [1:0]  err_code,
    input logic [12:0] mem_addr,
    input logic [7:0]  mem_dq_out,
    input logic        mem_dq_oe,
    input logic        mem_ce_n,
    input logic        mem_oe_n,
    input logic        mem_we_n
);
    int         lo_run, hi_run;
    logic       seen_rise;
    logic [6:0] page_q;
    logic [5:0] offs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run    <= 0;
            hi_run    <= 0;
            seen_rise <= 1'b0;
            page_q    <= '0;
            offs_q    <= '0;
        end else begin
            lo_run <= mem_we_n ? 0 : lo_run + 1;
            hi_run <= !mem_we_n ? 0 : ((hi_run < GAP_LIMIT + 2) ? hi_run + 1 : hi_run);
            if (req_valid && req_ready) begin
                page_q    <= req_page;
                offs_q    <= '0;
                seen_rise <= 1'b0;
            end else if (mem_we_n && lo_run != 0) begin
                seen_rise <= 1'b1;
                offs_q    <= offs_q + 1'b1;
            end
        end
    end

    a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (done || err) |=> !(done || err) && req_ready);
    a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    a_r2_empty_reject: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_count == 7'd0 |=> err && err_code == 2'd1 && mem_we_n);
    a_r3_page_bits: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_addr[12:6] == page_q);
    a_r3_offset_order: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_addr[5:0] == offs_q);
    a_r4_low_width: assert property (@(posedge clk) disable iff (rst)
        mem_we_n && lo_run != 0 |-> lo_run >= T_WP);
    a_r4_high_width: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n && hi_run != 0 && seen_rise |-> hi_run >= T_WPH);
    a_r4_stable_low: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n && lo_run != 0 |-> $stable(mem_addr) && $stable(mem_dq_out));
    a_r5_window: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n && hi_run != 0 && seen_rise |-> hi_run <= GAP_LIMIT);
    a_r6_drive_low_only: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);
    a_r6_release_first: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe && !$past(mem_dq_oe));
    a_r10_idle_bus: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n && mem_we_n && mem_oe_n);

endmodule

bind eeprog_page_writer eeprog_page_writer_chk #(
    .T_WP(T_WP), .T_WPH(T_WPH), .GAP_LIMIT(GAP_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_count(req_count), .done(done), .err(err),
    .err_code(err_code), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n)
);

// File: tb/eeprog_page_writer_test.sv
module eeprog_page_writer_test;
    localparam int T_AS = 1, T_WP = 6, T_WPH = 4, T_RD = 5, T_RH = 3;
    localparam int GAP = 40, POLL = 3000;

    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic req_valid = 0, req_ready, req_mode = 0, wr_valid = 0, wr_ready;
    logic [6:0] req_page = 0, req_count = 0;
    logic [7:0] wr_data = 0, mem_dq_out, dev_rd = 0;
    logic done, err, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0] err_code;
    logic [12:0] mem_addr;

    eeprog_page_writer #(.T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH), .T_RD(T_RD),
        .T_RH(T_RH), .GAP_LIMIT(GAP), .POLL_LIMIT(POLL)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_count(req_count), .req_mode(req_mode),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .done(done), .err(err), .err_code(err_code), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(dev_rd),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int page, input int k, input bit b7);
        return {b7, 7'(page * 37 + k * 11 + 5)};
    endfunction

    // behavioural memory
    logic [7:0] dev_mem [int];
    int   pend_a[$], log_a[$];
    logic [7:0] pend_d[$], log_d[$];
    int   busy_left = 0, busy_load = 300, lo_run = 0, hi_run = 0;
    int   min_lo, min_hi, max_hi, rd_cnt, rd_addr;
    bit   seen_rise = 0, tog = 0, we_q = 1, oe_q = 1;
    int   lat_a = 0, last_a = 0;
    logic [7:0] lat_d = 0, last_d = 0;

    always @(posedge clk) begin
        if (!rst) begin
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0)
                    while (pend_a.size() > 0) dev_mem[pend_a.pop_front()] = pend_d.pop_front();
            end
            if (we_q && !mem_we_n) begin
                lat_a = int'(mem_addr);
                if (seen_rise) begin
                    if (hi_run < min_hi) min_hi = hi_run;
                    if (hi_run > max_hi) max_hi = hi_run;
                end
                lo_run = 1;
            end else if (!mem_we_n) lo_run++;
            if (!mem_we_n) lat_d = mem_dq_out;
            if (!we_q && mem_we_n) begin
                if (lo_run < min_lo) min_lo = lo_run;
                log_a.push_back(lat_a); log_d.push_back(lat_d);
                pend_a.push_back(lat_a); pend_d.push_back(lat_d);
                busy_left = busy_load; tog = 0;
                last_a = lat_a; last_d = lat_d;
                seen_rise = 1; hi_run = 1;
            end else if (mem_we_n) hi_run++;
            if (oe_q && !mem_oe_n) begin
                rd_cnt++; rd_addr = int'(mem_addr);
                if (busy_left > 0) begin
                    dev_rd = {~last_d[7], tog, 6'b0};
                    tog = ~tog;
                end else
                    dev_rd = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 8'hFF;
            end
            we_q = mem_we_n; oe_q = mem_oe_n;
        end
    end

    // per-cycle comparison against the bench's own expectation
    bit outstanding = 0, job_end = 0, end_done = 0, wprev = 1;
    int end_code = 0, since_rise = 0, fin_rise = 0, end_busy = 0, cyc = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (mem_we_n && !wprev) since_rise = 0; else since_rise++;
            wprev = mem_we_n;
            chk(req_ready == !outstanding, "R1", "req_ready", req_ready, !outstanding);
            chk(!(mem_dq_oe && mem_we_n), "R6", "dq driven with we high", mem_dq_oe, 0);
            if (req_ready) chk(mem_ce_n && mem_we_n && mem_oe_n, "R10", "idle strobes",
                               {mem_ce_n, mem_we_n, mem_oe_n}, 7);
            chk(!(done && err), "R1", "done and err together", done & err, 0);
            if (done || err) begin
                chk(outstanding, "R1", "pulse without job", 0, 1);
                job_end = 1; end_done = done; end_code = err ? int'(err_code) : 0;
                fin_rise = since_rise; end_busy = busy_left; outstanding = 0;
            end
            if (cyc > 150000) begin
                chk(0, "R1", "watchdog expired", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", fails, checks);
                $finish;
            end
        end
    end

    int accepted;

    task automatic run_job(input int page, input int cnt, input bit mode,
                           input int avail, input int bcyc, input bit b7);
        while (busy_left > 0) @(negedge clk);
        busy_load = bcyc;
        log_a.delete(); log_d.delete();
        seen_rise = 0; min_lo = 1 << 30; min_hi = 1 << 30; max_hi = 0; rd_cnt = 0;
        accepted = 0; job_end = 0;
        @(negedge clk);
        req_valid = 1; req_page = 7'(page); req_count = 7'(cnt); req_mode = mode;
        @(posedge clk); #1;
        outstanding = 1; req_valid = 0;
        for (int guard = 0; guard < 20000 && !job_end; guard++) begin
            @(negedge clk);
            wr_valid = (accepted < avail);
            wr_data  = pat(page, accepted, b7);
            if (wr_valid && wr_ready) accepted++;
        end
        wr_valid = 0;
        chk(job_end, "R1", "job finished", job_end, 1);
    endtask

    task automatic check_loads(input string req, input int page, input int n, input bit b7);
        chk(log_a.size() == n, req, "strobe count", log_a.size(), n);
        for (int k = 0; k < n && k < log_a.size(); k++) begin
            chk(log_a[k] == page * 64 + k, "R3", "byte address", log_a[k], page * 64 + k);
            chk(log_d[k] == pat(page, k, b7), "R3", "byte data", log_d[k], pat(page, k, b7));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        chk(!done && !err, "R1", "no pulse after reset", done | err, 0);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R10", "strobes after reset",
            {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        chk(!mem_dq_oe, "R6", "bus released after reset", mem_dq_oe, 0);

        // toggle polling, 4 bytes
        run_job(5, 4, 0, 4, 300, 1);
        chk(end_done && end_code == 0, "R7", "toggle job result", end_code, 0);
        chk(end_busy == 0, "R7", "done only after memory idle", end_busy, 0);
        chk(rd_cnt >= 2, "R7", "at least two reads", rd_cnt, 2);
        check_loads("R3", 5, 4, 1);
        chk(min_lo >= T_WP, "R4", "min we low", min_lo, T_WP);
        chk(min_hi >= T_WPH, "R4", "min we high", min_hi, T_WPH);
        chk(dev_mem.exists(5 * 64 + 3) && dev_mem[5 * 64 + 3] == pat(5, 3, 1), "R3",
            "programmed byte", dev_mem[5 * 64 + 3], pat(5, 3, 1));

        // data polling, clamp 100 -> 64, last bit7 = 1
        run_job(127, 100, 1, 70, 400, 1);
        chk(accepted == 64, "R2", "clamped byte count", accepted, 64);
        check_loads("R2", 127, 64, 1);
        chk(end_done && end_code == 0, "R8", "data poll result", end_code, 0);
        chk(end_busy == 0, "R8", "done only after memory idle", end_busy, 0);
        chk(rd_addr == 127 * 64 + 63, "R8", "poll address", rd_addr, 127 * 64 + 63);
        chk(max_hi <= GAP, "R5", "max rise-to-fall", max_hi, GAP);

        // data polling, last bit7 = 0
        run_job(2, 3, 1, 3, 250, 0);
        chk(end_done && end_code == 0, "R8", "data poll result bit7 low", end_code, 0);
        chk(end_busy == 0, "R8", "idle at done bit7 low", end_busy, 0);
        chk(rd_addr == 2 * 64 + 2, "R8", "poll address bit7 low", rd_addr, 2 * 64 + 2);

        // empty request
        run_job(9, 0, 0, 4, 300, 1);
        chk(!end_done && end_code == 1, "R2", "empty request code", end_code, 1);
        chk(log_a.size() == 0, "R2", "no strobes on empty", log_a.size(), 0);
        chk(accepted == 0, "R2", "no bytes taken on empty", accepted, 0);

        // memory never finishes in time
        run_job(17, 2, 0, 2, 5000, 1);
        chk(!end_done && end_code == 2, "R9", "timeout code", end_code, 2);
        chk(fin_rise == T_WPH + POLL, "R9", "timeout cycle", fin_rise, T_WPH + POLL);

        // stream stalls after two bytes
        run_job(33, 6, 0, 2, 200, 1);
        chk(!end_done && end_code == 3, "R5", "window miss code", end_code, 3);
        check_loads("R5", 33, 2, 1);
        chk(end_busy == 0, "R5", "miss still polls to completion", end_busy, 0);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule